// File: doc/BRIEF.md
# Round-Robin SPI Channel Scheduler

This block shares one SPI shift register among several logical channels. Each channel holds one transmit word and one receive word. Each channel also has an enable input and a mode input, which selects either transmit-and-receive or transmit-only. While the shifter is idle, the scheduler picks the next eligible channel in rotation. It moves that channel's transmit word into the shifter, clocks the word out MSB first while it captures the incoming bits, and then writes the captured word into that channel's receive register.

The host writes transmit words through a valid/ready stream. The write carries a channel number, and `tx_ready_o` stays high only while that channel's transmit register is empty. A write offered to a full channel is held back until the shifter takes that channel's word. The host reads receive words through a second valid/ready stream. It selects the channel with `rx_chan_i`, `rx_valid_o` reports that the channel's receive register is full, and a handshake empties it. A transmit-and-receive channel that holds an unread word is therefore back-pressured: the scheduler does not serve it again until the word is read. `rx_full_o` also serves as the per-channel receive interrupt and DMA request.

A bit is shifted on every cycle in which `bit_tick_i` is high. Per-channel status outputs show whether the transmit register is empty, whether the receive register is full, and whether a transfer has ended. A one-cycle underflow pulse marks any enabled channel with nothing to send that was passed over during a grant.

Top module: `spi_chan_sched`

## Requirements
- R1: After reset every transmit register is empty, no receive register is full, no end-of-transfer or underflow flag is set, the shifter is idle and `tx_ready_o` is high.
- R2: `tx_ready_o` equals the empty flag of the channel on `tx_chan_i`. An accepted write stores `tx_data_i`, clears that channel's transmit-empty flag and clears its end-of-transfer flag.
- R3: A channel whose `ch_en_i` bit is 0 is never granted, even when it holds data.
- R4: Only a channel that holds a transmit word is granted. On the grant the word moves to the shifter, the channel's transmit-empty flag sets and `busy_o` rises one cycle later.
- R5: On a grant, each enabled channel with an empty transmit register that the rotation passed before reaching the winner raises `tx_underflow_o` for exactly one cycle, in the cycle in which `busy_o` first reads high. No other channel raises it.
- R6: A channel with `ch_txonly_i`=0 (transmit-and-receive) is skipped without underflow while its receive register is full, so its received data is never overwritten.
- R7: A channel with `ch_txonly_i`=1 (transmit-only) is served even when its receive register holds data. Its receive register is overwritten by each new word, and its `rx_full_o` bit never sets.
- R8: A transfer takes WORD_W ticks. At its end `busy_o` drops, the captured word enters the served channel's receive register and that channel's end-of-transfer flag sets.
- R9: The rotation starts its search at the channel after the one last served and wraps from channel NCH-1 to channel 0.
- R10: `rx_valid_o` equals the receive-full flag of the channel on `rx_chan_i`. `rx_data_o` shows that channel's receive register, and a handshake clears the flag.
- R11: When no channel is eligible the shifter stays idle, and no underflow is raised.
- R12: `mosi_o` presents the word MSB first and advances by one bit per tick. `miso_i` is captured on the same ticks, so the first bit received ends in the MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick_i | input | 1 | Shift enable, one bit per high cycle |
| ch_en_i | input | NCH | Per-channel enable |
| ch_txonly_i | input | NCH | Per-channel mode, 1 = transmit-only, 0 = transmit-and-receive |
| tx_valid_i | input | 1 | Transmit write valid |
| tx_ready_o | output | 1 | Transmit register of the addressed channel is empty |
| tx_chan_i | input | CW | Channel addressed by the transmit write |
| tx_data_i | input | WORD_W | Transmit word |
| rx_chan_i | input | CW | Channel addressed by the receive read |
| rx_valid_o | output | 1 | Addressed receive register holds an unread word |
| rx_ready_i | input | 1 | Host accepts the receive word |
| rx_data_o | output | WORD_W | Receive register of the addressed channel |
| miso_i | input | 1 | Serial data in |
| mosi_o | output | 1 | Serial data out |
| busy_o | output | 1 | Shifter is running a transfer |
| cur_chan_o | output | CW | Channel of the current or last transfer |
| tx_empty_o | output | NCH | Transmit register empty flags |
| rx_full_o | output | NCH | Receive full flags, also the receive interrupt and DMA request |
| eot_o | output | NCH | End-of-transfer flags |
| tx_underflow_o | output | NCH | One-cycle underflow pulses |

## Verification
A single word on one channel, with the serial input looped back inverted, shows MSB-first ordering and that the captured word lands in the right register. Several loaded channels show the rotation order. Loading a channel again after a low-numbered one has been served separates true rotation from fixed priority. Patterns with empty enabled channels in front of the one holding data check which underflow bits fire, and a pattern with no data at all must stay silent. An unread transmit-and-receive channel set beside a transmit-only channel shows the difference between being held back and being overwritten.

// File: rtl/spi_sched_pkg.sv
package spi_sched_pkg;
  typedef enum logic {CH_MODE_TRX = 1'b0, CH_MODE_TXO = 1'b1} ch_mode_e;

  function automatic int wrap_add(int a, int b, int n);
    return (a + b) % n;
  endfunction
endpackage

// File: rtl/rr_pick.sv
module rr_pick
  import spi_sched_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [CW-1:0]  start_i,
  input  logic [NCH-1:0] en_i,
  input  logic [NCH-1:0] elig_i,
  input  logic [NCH-1:0] empty_i,
  output logic           gnt_vld_o,
  output logic [CW-1:0]  gnt_idx_o,
  output logic [NCH-1:0] skip_empty_o
);
  always_comb begin
    int c;
    gnt_vld_o    = 1'b0;
    gnt_idx_o    = '0;
    skip_empty_o = '0;
    for (int i = 0; i < NCH; i++) begin
      c = wrap_add(int'(start_i), i, NCH);
      if (!gnt_vld_o && en_i[c]) begin
        if (elig_i[c]) begin
          gnt_vld_o = 1'b1;
          gnt_idx_o = CW'(c);
        end else if (empty_i[c]) begin
          skip_empty_o[c] = 1'b1;
        end
      end
    end
    if (!gnt_vld_o) skip_empty_o = '0;
  end
endmodule

// File: rtl/word_shifter.sv
module word_shifter #(
  parameter int WORD_W = 8,
  localparam int CNTW = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_word_i,
  input  logic              tick_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              mosi_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rx_word_o
);
  logic [WORD_W-1:0] sh_q;
  logic [CNTW-1:0]   cnt_q;
  logic              last;

  assign last      = (cnt_q == CNTW'(WORD_W - 1));
  assign done_o    = busy_o & tick_i & last;
  assign mosi_o    = sh_q[WORD_W-1];
  assign rx_word_o = {sh_q[WORD_W-2:0], miso_i};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_o <= 1'b0;
    end else if (load_i && !busy_o) begin
      sh_q   <= load_word_i;
      cnt_q  <= '0;
      busy_o <= 1'b1;
    end else if (busy_o && tick_i) begin
      sh_q  <= {sh_q[WORD_W-2:0], miso_i};
      cnt_q <= cnt_q + 1'b1;
      if (last) busy_o <= 1'b0;
    end
  end

  AST_WORD_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> ($past(tick_i) && $past(cnt_q) == CNTW'(WORD_W - 1))); // R8
  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !busy_o); // R11
endmodule

// File: rtl/spi_chan_sched.sv
module spi_chan_sched
  import spi_sched_pkg::*;
#(
  parameter int NCH = 4,
  parameter int WORD_W = 8,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick_i,
  input  logic [NCH-1:0]    ch_en_i,
  input  logic [NCH-1:0]    ch_txonly_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  input  logic [CW-1:0]     tx_chan_i,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic [CW-1:0]     rx_chan_i,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic [WORD_W-1:0] rx_data_o,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic              busy_o,
  output logic [CW-1:0]     cur_chan_o,
  output logic [NCH-1:0]    tx_empty_o,
  output logic [NCH-1:0]    rx_full_o,
  output logic [NCH-1:0]    eot_o,
  output logic [NCH-1:0]    tx_underflow_o
);
  logic [WORD_W-1:0] tx_hold [NCH];
  logic [WORD_W-1:0] rx_hold [NCH];
  logic [NCH-1:0]    tx_empty_q, rx_full_q, eot_q, uf_q, elig, skip_empty;
  logic [CW-1:0]     ptr_q, cur_q, gnt_idx;
  logic              gnt_vld, start, done, wr_fire, rd_fire;
  logic [WORD_W-1:0] rx_word;

  // A transmit-only channel ignores its receive-full state
  assign elig    = ch_en_i & ~tx_empty_q & (ch_txonly_i | ~rx_full_q);
  assign start   = gnt_vld & ~busy_o;
  assign wr_fire = tx_valid_i & tx_ready_o;
  assign rd_fire = rx_valid_o & rx_ready_i;

  assign tx_ready_o     = tx_empty_q[tx_chan_i];
  assign rx_valid_o     = rx_full_q[rx_chan_i];
  assign rx_data_o      = rx_hold[rx_chan_i];
  assign cur_chan_o     = cur_q;
  assign tx_empty_o     = tx_empty_q;
  assign rx_full_o      = rx_full_q;
  assign eot_o          = eot_q;
  assign tx_underflow_o = uf_q;

  rr_pick #(.NCH(NCH)) u_pick (
    .start_i      (ptr_q),
    .en_i         (ch_en_i),
    .elig_i       (elig),
    .empty_i      (tx_empty_q),
    .gnt_vld_o    (gnt_vld),
    .gnt_idx_o    (gnt_idx),
    .skip_empty_o (skip_empty)
  );

  word_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (start),
    .load_word_i (tx_hold[gnt_idx]),
    .tick_i      (bit_tick_i),
    .miso_i      (miso_i),
    .busy_o      (busy_o),
    .mosi_o      (mosi_o),
    .done_o      (done),
    .rx_word_o   (rx_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cur_q <= '0;
    end else if (start) begin
      cur_q <= gnt_idx;
      ptr_q <= CW'(wrap_add(int'(gnt_idx), 1, NCH));
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic sel_start, sel_done, sel_wr, sel_rd;
    assign sel_start = start   && (gnt_idx == CW'(g));
    assign sel_done  = done    && (cur_q == CW'(g));
    assign sel_wr    = wr_fire && (tx_chan_i == CW'(g));
    assign sel_rd    = rd_fire && (rx_chan_i == CW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tx_hold[g]    <= '0;
        rx_hold[g]    <= '0;
        tx_empty_q[g] <= 1'b1;
        rx_full_q[g]  <= 1'b0;
        eot_q[g]      <= 1'b0;
        uf_q[g]       <= 1'b0;
      end else begin
        uf_q[g] <= start && skip_empty[g];
        if (sel_start)   tx_empty_q[g] <= 1'b1;
        else if (sel_wr) tx_empty_q[g] <= 1'b0;
        if (sel_wr) tx_hold[g] <= tx_data_i;
        if (sel_done)    eot_q[g] <= 1'b1;
        else if (sel_wr) eot_q[g] <= 1'b0;
        if (sel_done) rx_hold[g] <= rx_word;
        if (sel_done)    rx_full_q[g] <= (ch_txonly_i[g] == CH_MODE_TRX);
        else if (sel_rd) rx_full_q[g] <= 1'b0;
      end
    end

    AST_TXONLY_NEVER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_full_q[g]) |-> !$past(ch_txonly_i[g])); // R7
    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_done && !ch_txonly_i[g]) |-> !rx_full_q[g]); // R6
  end

  AST_GRANT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> ch_en_i[gnt_idx]); // R3
  AST_GRANT_TAKES_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (tx_empty_q[$past(gnt_idx)] && busy_o)); // R4
  AST_UF_ONLY_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (|uf_q) |-> $past(start)); // R5
  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !tx_empty_q[$past(tx_chan_i)]); // R2
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> !rx_full_q[$past(rx_chan_i)]); // R10
endmodule

// File: tb/spi_chan_sched_tb.sv
module spi_chan_sched_tb;
  localparam int NCH = 4;
  localparam int W   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b1;
  logic [NCH-1:0] ch_en = '0, ch_txonly = '0;
  logic tx_valid = 1'b0, rx_ready = 1'b0;
  logic [1:0] tx_chan = '0, rx_chan = '0;
  logic [W-1:0] tx_data = '0;
  logic tx_ready, rx_valid, mosi, busy;
  logic [W-1:0] rx_data;
  logic [1:0] cur_chan;
  logic [NCH-1:0] tx_empty, rx_full, eot, uf;
  logic miso;

  int n_chk = 0, n_fail = 0;

  assign miso = ~mosi;  // inverted loopback: received word = ~sent word

  always #2 clk = ~clk;

  spi_chan_sched #(.NCH(NCH), .WORD_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick_i(bit_tick),
    .ch_en_i(ch_en), .ch_txonly_i(ch_txonly),
    .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .tx_chan_i(tx_chan), .tx_data_i(tx_data),
    .rx_chan_i(rx_chan), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready), .rx_data_o(rx_data),
    .miso_i(miso), .mosi_o(mosi), .busy_o(busy), .cur_chan_o(cur_chan),
    .tx_empty_o(tx_empty), .rx_full_o(rx_full), .eot_o(eot), .tx_underflow_o(uf)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ch_en = '0; ch_txonly = '0; tx_valid = 1'b0; rx_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input int ch, input logic [W-1:0] d);
    tx_chan = 2'(ch); tx_data = d; tx_valid = 1'b1;
    #0;
    chk(tx_ready === 1'b1, "R2 ready on empty", 32'(tx_ready), 1);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic rd(input int ch, output logic [W-1:0] d, output logic v);
    rx_chan = 2'(ch); rx_ready = 1'b1;
    #0;
    d = rx_data; v = rx_valid;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic wait_start(output int ch, output logic [NCH-1:0] u);
    int n = 0;
    while (busy !== 1'b1 && n < 60) begin @(negedge clk); n++; end
    chk(busy === 1'b1, "R4 transfer started", 32'(busy), 1);
    ch = int'(cur_chan); u = uf;
  endtask

  task automatic wait_done();
    int n = 0;
    while (busy === 1'b1 && n < 60) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset();
    do_reset();
    chk(tx_empty == 4'hF && rx_full == 0 && eot == 0, "R1 flags", {tx_empty, rx_full, eot}, 12'hF00);
    chk(busy == 0 && uf == 0 && tx_ready == 1, "R1 idle", {busy, uf, tx_ready}, 1);
  endtask

  task automatic t_single();
    int ch; logic [NCH-1:0] u; logic [W-1:0] bits, d; logic v;
    do_reset();
    ch_en = 4'b0001;
    wr(0, 8'hA5);
    chk(tx_empty[0] == 0 && eot[0] == 0, "R2 write fills", 32'(tx_empty[0]), 0);
    wait_start(ch, u);
    chk(ch == 0 && tx_empty[0] == 1, "R4 granted ch0 word taken", {ch[7:0], 7'b0, tx_empty[0]}, 1);
    for (int b = W - 1; b >= 0; b--) begin bits[b] = mosi; @(negedge clk); end
    chk(bits == 8'hA5, "R12 mosi MSB first", bits, 8'hA5);
    chk(busy == 0 && eot[0] == 1, "R8 end after WORD_W ticks", {busy, eot[0]}, 1);
    rd(0, d, v);
    chk(v == 1 && d == 8'h5A, "R8 R10 rx word", {v, d}, {1'b1, 8'h5A});
    chk(rx_full[0] == 0, "R10 read clears", 32'(rx_full[0]), 0);
    wr(0, 8'h11);
    chk(eot[0] == 0, "R2 write clears eot", 32'(eot[0]), 0);
  endtask

  task automatic t_disabled();
    do_reset();
    ch_en = 4'b1101;
    wr(1, 8'h77);
    repeat (20) begin
      @(negedge clk);
      if (busy) break;
    end
    chk(busy == 0 && tx_empty[1] == 0, "R3 disabled not served", {busy, tx_empty[1]}, 0);
    chk(uf == 0, "R11 no eligible no underflow", uf, 0);
  endtask

  task automatic t_rotation();
    int ch; logic [NCH-1:0] u;
    do_reset();
    ch_en = 4'b0010;
    wr(1, 8'h01);
    wait_start(ch, u); wait_done();
    chk(ch == 1, "R9 first served", ch, 1);
    wr(0, 8'h02); wr(3, 8'h03);
    ch_en = 4'b1011;
    wait_start(ch, u); wait_done();
    chk(ch == 3, "R9 search starts after last served", ch, 3);
    wait_start(ch, u); wait_done();
    chk(ch == 0, "R9 wraps to channel 0", ch, 0);
  endtask

  task automatic t_underflow();
    int ch; logic [NCH-1:0] u;
    do_reset();
    ch_en = 4'b1111;
    wr(3, 8'h33);
    wait_start(ch, u);
    chk(ch == 3 && u == 4'b0111, "R5 skipped empties pulse", {ch[3:0], u}, {4'd3, 4'b0111});
    @(negedge clk);
    chk(uf == 0, "R5 pulse one cycle", uf, 0);
    wait_done();
    wr(2, 8'h22);
    wait_start(ch, u); wait_done();
    chk(ch == 2 && u == 4'b0011, "R5 only channels passed over", {ch[3:0], u}, {4'd2, 4'b0011});
    repeat (10) begin
      @(negedge clk);
      chk(busy == 0 && uf == 0, "R11 idle silent", {busy, uf}, 0);
    end
  endtask

  task automatic t_modes();
    int ch; logic [NCH-1:0] u; logic [W-1:0] d; logic v;
    do_reset();
    ch_en = 4'b1110; ch_txonly = 4'b0010;
    wr(2, 8'hC0);
    wait_start(ch, u); wait_done();
    chk(rx_full[2] == 1, "R6 trx fills", 32'(rx_full[2]), 1);
    wr(2, 8'hC1);
    repeat (15) begin
      @(negedge clk);
      if (busy) break;
    end
    chk(busy == 0 && uf == 0 && tx_empty[2] == 0, "R6 full trx held back", {busy, uf, tx_empty[2]}, 0);
    wr(3, 8'hD0);
    wait_start(ch, u); wait_done();
    chk(ch == 3, "R6 other channel passes held one", ch, 3);
    rd(2, d, v);
    chk(v && d == 8'h3F, "R6 first word kept", {v, d}, {1'b1, 8'h3F});
    wait_start(ch, u); wait_done();
    chk(ch == 2, "R6 served after read", ch, 2);
    wr(1, 8'h3C);
    wait_start(ch, u); wait_done();
    wr(1, 8'h81);
    wait_start(ch, u); wait_done();
    rx_chan = 2'd1; #0;
    chk(rx_valid == 0 && rx_full[1] == 0, "R7 txonly never full", {rx_valid, rx_full[1]}, 0);
    chk(rx_data == 8'h7E && eot[1] == 1, "R7 overwritten", {eot[1], rx_data}, {1'b1, 8'h7E});
  endtask

  initial begin
    t_reset();
    t_single();
    t_disabled();
    t_rotation();
    t_underflow();
    t_modes();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule